// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns one asynchronous external interrupt pin into an interrupt request for a small microcontroller core. The pin passes through a synchroniser and a sampling register. Edge detection compares two consecutive samples. Depending on a run-time sense code, the block either keeps a pending flag set by the chosen edge or follows a low level on the pin directly. The request reaches the core only while the global interrupt enable and this source's mask bit are both set. The core clears the pending flag with a one-cycle acknowledge pulse.

An 8-bit control register sits at one bus address. Besides the sense code, it holds three plain control bits: pull-up disable, sleep enable and sleep mode. These drive outputs for neighbouring blocks. A sleep command from the core is passed on only while sleep enable is set.

Top module: `extint_sense_top`

## Requirements
- R1: After reset the control register reads 0x00, `intReq` is 0, and `pullupDisable`, `sleepEnable`, `sleepModeSel` and `sleepGo` are 0. The sampling registers reset to 1, the idle level of the pin.
- R2: Register bits 7, 3 and 2 always read 0 and ignore writes. Bits 6, 5, 4, 1 and 0 read back the last value written, so writing 0xFF reads back 0x73.
- R3: Reads at any address other than `REG_ADDR` return 0x00. Writes at such an address leave the register unchanged.
- R4: Sense code 00 (bits 1:0) is level mode. `intReq` is high, when enabled, exactly while the sampled pin is low, and no flag is latched.
- R5: Sense code 01 sets the pending flag on both a falling and a rising edge of the sampled pin.
- R6: Sense code 10 sets the pending flag on a falling edge only; a rising edge has no effect.
- R7: Sense code 11 sets the pending flag on a rising edge only; a falling edge has no effect.
- R8: A one-cycle `intAck` clears the pending flag. If an edge is detected in the same cycle as `intAck`, the flag stays set.
- R9: `intReq` is high only while `globalIe` and `intMask` are both 1. A pending flag is kept while the request is gated off and shows again once both are 1.
- R10: Changing the sense code alone never sets the pending flag. After a change, only an edge that occurs later counts.
- R11: `pullupDisable` is bit 6, `sleepEnable` is bit 5 and `sleepModeSel` is bit 4 (0 = idle, 1 = power-down). `sleepGo` equals `sleepCmd` gated by `sleepEnable`.
- R12: A pin change applied before rising clock edge k is seen at the sampling register at edge k+2. In level mode `intReq` changes after edge k+2; in edge modes the pending request appears after edge k+3. A low pulse of two clock periods is detected in falling-edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 1 | Asynchronous external interrupt pin |
| busAddr | input | ADDR_W | Register bus address |
| busWe | input | 1 | Register write strobe |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Register read data (combinational) |
| globalIe | input | 1 | Global interrupt enable flag |
| intMask | input | 1 | Mask bit for this source |
| intAck | input | 1 | Acknowledge pulse that clears the pending flag |
| sleepCmd | input | 1 | Sleep command from the core |
| intReq | output | 1 | Gated interrupt request |
| pullupDisable | output | 1 | Pull-up disable control |
| sleepEnable | output | 1 | Sleep enable control |
| sleepModeSel | output | 1 | Sleep mode: 0 idle, 1 power-down |
| sleepGo | output | 1 | Sleep command qualified by sleep enable |

## Verification
Two events can fall in the same cycle: the edge detector setting the pending flag and the core's acknowledge clearing it. The bench first leaves a flag pending in any-change mode. It then toggles the pin and counts the synchroniser stages, so that `intAck` is high at exactly the clock edge where the new sample differs from the previous one. The check passes if the request is still high after that edge. A second acknowledge with no edge must then drop the request, which shows the clear path works on its own.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] WR_MASK = 8'h73;

  localparam int BIT_PUD   = 6;
  localparam int BIT_SE    = 5;
  localparam int BIT_SM    = 4;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  typedef struct packed {
    logic riseEn;
    logic fallEn;
    logic ackClr;
  } dp_ctrl_t;
endpackage

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     pinIn,
  input  dp_ctrl_t ctrl,
  output logic     pinLow,
  output logic     edgeHit,
  output logic     pendingQ
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic sampleQ;
  logic prevQ;
  logic riseSeen;
  logic fallSeen;

  generate
    genvar gi;
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[gi] <= 1'b1;
          else       syncQ[gi] <= pinIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[gi] <= 1'b1;
          else       syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleQ <= 1'b1;
      prevQ   <= 1'b1;
    end else begin
      sampleQ <= syncQ[LAST];
      prevQ   <= sampleQ;
    end
  end

  assign riseSeen = sampleQ & ~prevQ;
  assign fallSeen = ~sampleQ & prevQ;
  assign edgeHit  = (ctrl.riseEn & riseSeen) | (ctrl.fallEn & fallSeen);
  assign pinLow   = ~sampleQ;

  always_ff @(posedge clk) begin
    if (!rstN)            pendingQ <= 1'b0;
    else if (edgeHit)     pendingQ <= 1'b1;
    else if (ctrl.ackClr) pendingQ <= 1'b0;
  end
endmodule

// File: rtl/extint_control.sv
module extint_control
  import extint_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int REG_ADDR = 'h35
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              globalIe,
  input  logic              intMask,
  input  logic              intAck,
  input  logic              sleepCmd,
  input  logic              pinLow,
  input  logic              pendingQ,
  output dp_ctrl_t          ctrl,
  output logic [DATA_W-1:0] ctrlReg,
  output logic              intReq,
  output logic              pullupDisable,
  output logic              sleepEnable,
  output logic              sleepModeSel,
  output logic              sleepGo
);
  localparam logic [ADDR_W-1:0] REG_SEL = REG_ADDR[ADDR_W-1:0];

  logic   hit;
  sense_e sense;
  logic   levelMode;
  logic   srcActive;

  assign hit = (busAddr == REG_SEL);

  always_ff @(posedge clk) begin
    if (!rstN)             ctrlReg <= '0;
    else if (busWe && hit) ctrlReg <= busWdata & WR_MASK;
  end

  assign busRdata = hit ? ctrlReg : '0;

  assign sense       = sense_e'(ctrlReg[1:0]);
  assign levelMode   = (sense == SENSE_LOW);
  assign ctrl.riseEn = (sense == SENSE_ANY) || (sense == SENSE_RISE);
  assign ctrl.fallEn = (sense == SENSE_ANY) || (sense == SENSE_FALL);
  assign ctrl.ackClr = intAck;

  assign srcActive = levelMode ? pinLow : pendingQ;
  assign intReq    = srcActive & globalIe & intMask;

  assign pullupDisable = ctrlReg[BIT_PUD];
  assign sleepEnable   = ctrlReg[BIT_SE];
  assign sleepModeSel  = ctrlReg[BIT_SM];
  assign sleepGo       = sleepCmd & sleepEnable;
endmodule

// File: rtl/extint_sense_top.sv
module extint_sense_top
  import extint_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int REG_ADDR    = 'h35,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              globalIe,
  input  logic              intMask,
  input  logic              intAck,
  input  logic              sleepCmd,
  output logic              intReq,
  output logic              pullupDisable,
  output logic              sleepEnable,
  output logic              sleepModeSel,
  output logic              sleepGo
);
  dp_ctrl_t          ctrl;
  logic              pinLow;
  logic              edgeHit;
  logic              pendingQ;
  logic [DATA_W-1:0] ctrlReg;

  extint_control #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .globalIe(globalIe), .intMask(intMask), .intAck(intAck), .sleepCmd(sleepCmd),
    .pinLow(pinLow), .pendingQ(pendingQ),
    .ctrl(ctrl), .ctrlReg(ctrlReg), .intReq(intReq),
    .pullupDisable(pullupDisable), .sleepEnable(sleepEnable),
    .sleepModeSel(sleepModeSel), .sleepGo(sleepGo)
  );

  extint_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .ctrl(ctrl),
    .pinLow(pinLow), .edgeHit(edgeHit), .pendingQ(pendingQ)
  );
endmodule

// File: rtl/extint_checker.sv
module extint_checker #(
  parameter int ADDR_W   = 6,
  parameter int REG_ADDR = 'h35
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [7:0]        busWdata,
  input logic [7:0]        busRdata,
  input logic              intAck,
  input logic              intReq,
  input logic              globalIe,
  input logic              intMask,
  input logic [7:0]        ctrlReg,
  input logic              pendingQ,
  input logic              edgeHit
);
  localparam logic [ADDR_W-1:0] REG_SEL = REG_ADDR[ADDR_W-1:0];

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRdata[7] == 1'b0) && (busRdata[3:2] == 2'b00));

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == REG_SEL) |=> (ctrlReg == ($past(busWdata) & 8'h73)));

  a_r3_foreign_read: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != REG_SEL) |-> (busRdata == 8'h00));

  a_r3_foreign_write: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr != REG_SEL) |=> $stable(ctrlReg));

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    edgeHit |=> pendingQ);

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !edgeHit) |=> !pendingQ);

  a_r9_gated: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (globalIe && intMask));

  a_r10_only_edges_set: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendingQ) |-> $past(edgeHit));
endmodule

bind extint_sense_top extint_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
  .busRdata(busRdata), .intAck(intAck), .intReq(intReq), .globalIe(globalIe),
  .intMask(intMask), .ctrlReg(ctrlReg), .pendingQ(pendingQ), .edgeHit(edgeHit)
);

// File: tb/extint_sense_top_bench.sv
module extint_sense_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;
  localparam int REG_ADDR   = 'h35;
  localparam logic [ADDR_W-1:0] RA = REG_ADDR[ADDR_W-1:0];

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinIn = 1'b1;
  logic [ADDR_W-1:0] busAddr = RA;
  logic busWe = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic globalIe = 1'b0, intMask = 1'b0, intAck = 1'b0, sleepCmd = 1'b0;
  logic intReq, pullupDisable, sleepEnable, sleepModeSel, sleepGo;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extint_sense_top #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_extint_sense_top (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .globalIe(globalIe), .intMask(intMask),
    .intAck(intAck), .sleepCmd(sleepCmd), .intReq(intReq),
    .pullupDisable(pullupDisable), .sleepEnable(sleepEnable),
    .sleepModeSel(sleepModeSel), .sleepGo(sleepGo)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeReg(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    tick(1);
    busWe = 1'b0; busAddr = RA;
  endtask

  task automatic readCheck(input string req, input logic [ADDR_W-1:0] a, input logic [7:0] exp);
    busAddr = a;
    #1;
    check(req, busRdata, exp);
    busAddr = RA;
  endtask

  task automatic ackPulse();
    intAck = 1'b1; tick(1); intAck = 1'b0;
  endtask

  task automatic t_reset();
    readCheck("R1 reg", RA, 8'h00);
    check("R1 intReq", {7'd0, intReq}, 8'h00);
    check("R1 ctrl outs", {4'd0, pullupDisable, sleepEnable, sleepModeSel, sleepGo}, 8'h00);
  endtask

  task automatic t_regmap();
    writeReg(RA, 8'hFF);
    readCheck("R2 readback FF", RA, 8'h73);
    check("R11 ctrl outs", {5'd0, pullupDisable, sleepEnable, sleepModeSel}, 8'h07);
    sleepCmd = 1'b1; #1;
    check("R11 sleepGo on", {7'd0, sleepGo}, 8'h01);
    writeReg(RA, 8'h8C);
    readCheck("R2 reserved only", RA, 8'h00);
    writeReg(RA, 8'h50);
    check("R11 pud/sm only", {5'd0, pullupDisable, sleepEnable, sleepModeSel}, 8'h05);
    check("R11 sleepGo blocked", {7'd0, sleepGo}, 8'h00);
    sleepCmd = 1'b0;
    writeReg(RA, 8'h00);
  endtask

  task automatic t_addr();
    writeReg(RA + 1'b1, 8'hFF);
    readCheck("R3 foreign write", RA, 8'h00);
    writeReg(RA, 8'h30);
    readCheck("R3 foreign read", RA - 1'b1, 8'h00);
    writeReg(RA, 8'h00);
  endtask

  task automatic t_level();
    writeReg(RA, 8'h00);
    pinIn = 1'b0;
    tick(2); check("R12 level not yet", {7'd0, intReq}, 8'h00);
    tick(1); check("R4 level low req", {7'd0, intReq}, 8'h01);
    tick(4); check("R4 level held", {7'd0, intReq}, 8'h01);
    pinIn = 1'b1;
    tick(3); check("R4 level released", {7'd0, intReq}, 8'h00);
  endtask

  task automatic t_fall();
    writeReg(RA, 8'h02);
    pinIn = 1'b0;
    tick(3); check("R12 edge not yet", {7'd0, intReq}, 8'h00);
    tick(1); check("R6 falling sets", {7'd0, intReq}, 8'h01);
    ackPulse(); check("R8 ack clears", {7'd0, intReq}, 8'h00);
    pinIn = 1'b1;
    tick(5); check("R6 rise ignored", {7'd0, intReq}, 8'h00);
    pinIn = 1'b0; tick(2); pinIn = 1'b1;
    tick(6); check("R12 short pulse caught", {7'd0, intReq}, 8'h01);
    ackPulse();
  endtask

  task automatic t_rise();
    writeReg(RA, 8'h03);
    pinIn = 1'b0;
    tick(5); check("R7 fall ignored", {7'd0, intReq}, 8'h00);
    pinIn = 1'b1;
    tick(5); check("R7 rising sets", {7'd0, intReq}, 8'h01);
    ackPulse();
  endtask

  task automatic t_any();
    writeReg(RA, 8'h01);
    pinIn = 1'b0;
    tick(5); check("R5 any fall", {7'd0, intReq}, 8'h01);
    ackPulse(); check("R5 cleared", {7'd0, intReq}, 8'h00);
    pinIn = 1'b1;
    tick(5); check("R5 any rise", {7'd0, intReq}, 8'h01);
    ackPulse();
  endtask

  task automatic t_gate();
    writeReg(RA, 8'h02);
    globalIe = 1'b0;
    pinIn = 1'b0;
    tick(5); check("R9 global off", {7'd0, intReq}, 8'h00);
    globalIe = 1'b1; #1;
    check("R9 pending kept", {7'd0, intReq}, 8'h01);
    intMask = 1'b0; #1;
    check("R9 masked", {7'd0, intReq}, 8'h00);
    intMask = 1'b1; #1;
    check("R9 unmasked", {7'd0, intReq}, 8'h01);
    ackPulse();
    pinIn = 1'b1; tick(5);
  endtask

  task automatic t_modechg();
    writeReg(RA, 8'h03); writeReg(RA, 8'h01); writeReg(RA, 8'h02);
    tick(3); check("R10 change pin high", {7'd0, intReq}, 8'h00);
    writeReg(RA, 8'h00);
    pinIn = 1'b0; tick(5);
    check("R10 level active", {7'd0, intReq}, 8'h01);
    writeReg(RA, 8'h03); tick(2);
    check("R10 to rise no flag", {7'd0, intReq}, 8'h00);
    writeReg(RA, 8'h02); tick(2);
    check("R10 to fall no flag", {7'd0, intReq}, 8'h00);
    pinIn = 1'b1; tick(5);
  endtask

  task automatic t_collide();
    writeReg(RA, 8'h01);
    pinIn = 1'b0; tick(5);
    check("R8 pre pending", {7'd0, intReq}, 8'h01);
    pinIn = 1'b1;
    tick(3);
    intAck = 1'b1; tick(1); intAck = 1'b0;
    check("R8 set beats ack", {7'd0, intReq}, 8'h01);
    ackPulse();
    check("R8 lone ack clears", {7'd0, intReq}, 8'h00);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    t_reset();
    t_regmap();
    t_addr();
    globalIe = 1'b1; intMask = 1'b1;
    t_level();
    t_fall();
    t_rise();
    t_any();
    t_gate();
    t_modechg();
    t_collide();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule